// File: doc/BRIEF.md
# Sequential Node Address Programmer

This block hands out unique node addresses to a row of devices that share one single-wire serial bus. The devices are linked by a release chain: each device's next-address output feeds the next device's next-address input. Until it is programmed, the first device in that chain answers at node address 0. Once programmed, a device pulls its next-address output low, and this lets the following device answer at address 0 in its turn.

After a start pulse, the block walks the chain from logical index 0 upward. For each device it works through three steps. First it issues a configuration write to node 0 through a generic register request port. Then it waits a prescaled settle time so the release line can change. Last it reads the configuration register back at the new address and compares the whole word. Each verified result goes into a table indexed by logical position. That table is stored in an inferable memory and has a registered read port. The first failed write or failed readback stops the walk and records the failing index. The frame format and checksum of the bus sit behind the request port.

Top module: `node_addr_programmer`

## Requirements
- R1: The device at logical index i is assigned node address 254 - i. The address is carried in bits 7:0 of the configuration write data, and bits DATA_W-1:12 are zero.
- R2: Every configuration write has req_write = 1, req_node = 0 and req_reg = CFG_REG.
- R3: Bits 11:8 of the configuration write data hold the send-delay value. This value is SEND_DELAY, raised to 2 when SEND_DELAY is smaller than 2.
- R4: Devices are handled strictly in index order. The write for index i+1 is issued only after the readback of index i has matched. No index is skipped, and at most one request is outstanding at a time.
- R5: Between the acknowledged write of a device and its readback request, at least PRESCALE*SETTLE_TICKS clock cycles pass.
- R6: The readback is a read (req_write = 0) of CFG_REG at node 254 - i. The readback passes only if resp_ok = 1 and resp_data equals the written word exactly. If it fails, error is raised, fail_idx = i, and the walk stops.
- R7: If a configuration write returns resp_ok = 0, error is raised, fail_idx = i, and no further request is issued.
- R8: A request holds req_valid and its fields stable until the cycle in which resp_valid = 1 is sampled. req_valid is low in the next cycle.
- R9: After the last of node_count devices is verified, done is raised. Table entries 0 to node_count-1 then read back as valid with address 254 - i, and entries that were not verified read back as invalid. done and error are never high together.
- R10: A start with node_count = 0 raises done and issues no request. A start with node_count greater than MAX_NODES raises error with fail_idx = 0 and issues no request.
- R11: A start pulse while a walk is in progress is ignored, and so is the node_count presented with it. An accepted start clears done, error and every table valid flag.
- R12: After reset, done, error and req_valid are low and every table entry reads back as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a programming walk (acted on only when idle) |
| node_count | input | IDX_W | Number of devices to program, sampled at start |
| req_valid | output | 1 | Register request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_node | output | 8 | Target node address |
| req_reg | output | 8 | Target register |
| req_data | output | DATA_W | Write data (zero for reads) |
| resp_valid | input | 1 | Response for the pending request |
| resp_ok | input | 1 | 1 = acknowledged, 0 = refused |
| resp_data | input | DATA_W | Read data returned with a read response |
| tbl_idx | input | IDX_W | Table read index |
| tbl_addr | output | 8 | Programmed address of tbl_idx, one cycle later |
| tbl_valid | output | 1 | Entry tbl_idx has been verified, one cycle later |
| done | output | 1 | Walk finished with all devices verified |
| error | output | 1 | Walk stopped on a failure |
| fail_idx | output | IDX_W | Logical index at which the walk stopped |

## Verification
The checker watches every cycle for the rules that can be seen on the request port. These are: configuration writes target node 0 and the configuration register, the delay field is at least 2, the address field stays inside the window of 254 down, and each readback targets the address that was just written. It also checks that requests stay stable until answered and are dropped afterward, that the settle gap is never shortened, and that done and error are never high together. Only the bench scenarios can show the rest. That covers the exact address sequence across a whole walk, where the walk stops after a refused write or a corrupted readback, the empty and oversized counts, a start pulse ignored in mid-walk, and the contents and clearing of the address table.

// File: rtl/nap_pkg.sv
package nap_pkg;
  localparam int unsigned NODE_W = 8;
  localparam logic [NODE_W-1:0] TOP_NODE_ADDR  = 8'd254;
  localparam logic [NODE_W-1:0] OPEN_NODE_ADDR = 8'd0;
  localparam int unsigned MIN_SEND_DELAY = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETTLE,
    ST_READ,
    ST_NEXT
  } seq_state_t;
endpackage

// File: rtl/nap_settle_timer.sv
module nap_settle_timer #(
  parameter int PRESCALE     = 1000,
  parameter int SETTLE_TICKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int TICK_W = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;

  logic              running;
  logic              tick;
  logic [TICK_W-1:0] ticks_left;

  generate
    if (PRESCALE > 1) begin : g_prescale
      logic [PRE_W-1:0] pre_cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          pre_cnt <= PRE_W'(PRESCALE - 1);
        end else if (start) begin
          pre_cnt <= PRE_W'(PRESCALE - 1);
        end else if (running) begin
          if (pre_cnt == '0) pre_cnt <= PRE_W'(PRESCALE - 1);
          else               pre_cnt <= pre_cnt - 1'b1;
        end
      end
      assign tick = running && (pre_cnt == '0);
    end else begin : g_direct
      assign tick = running;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      ticks_left <= '0;
      expired    <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        running    <= 1'b1;
        ticks_left <= TICK_W'(SETTLE_TICKS - 1);
      end else if (tick) begin
        if (ticks_left == '0) begin
          running <= 1'b0;
          expired <= 1'b1;
        end else begin
          ticks_left <= ticks_left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nap_addr_table.sv
module nap_addr_table #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 5,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata,
  output logic             rvalid
);
  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic             w_in_range;
  logic             r_in_range;

  assign w_in_range = (waddr < IDX_W'(DEPTH));
  assign r_in_range = (raddr < IDX_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (we && w_in_range) mem[waddr[AW-1:0]] <= wdata;
    rdata <= mem[raddr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      vld <= '0;
    end else if (we && w_in_range) begin
      vld[waddr[AW-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= r_in_range && vld[raddr[AW-1:0]];
  end
endmodule

// File: rtl/nap_sequencer.sv
module nap_sequencer
  import nap_pkg::*;
#(
  parameter int         MAX_NODES   = 16,
  parameter int         IDX_W       = 5,
  parameter int         DATA_W      = 32,
  parameter logic [7:0] CFG_REG     = 8'h03,
  parameter logic [3:0] DELAY_FIELD = 4'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  node_count,
  input  logic              timer_expired,
  output logic              timer_start,
  output logic              req_valid,
  output logic              req_write,
  output logic [7:0]        req_node,
  output logic [7:0]        req_reg,
  output logic [DATA_W-1:0] req_data,
  input  logic              resp_valid,
  input  logic              resp_ok,
  input  logic [DATA_W-1:0] resp_data,
  output logic              tbl_clear,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_waddr,
  output logic [7:0]        tbl_wdata,
  output logic              done,
  output logic              error,
  output logic [IDX_W-1:0]  fail_idx
);
  seq_state_t        st;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  cnt_q;
  logic [DATA_W-1:0] wr_word;
  logic [7:0]        target;
  logic              rd_match;
  logic              last_node;

  function automatic logic [DATA_W-1:0] cfg_word(input logic [7:0] node);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[11:8]  = DELAY_FIELD;
    w[7:0]   = node;
    return w;
  endfunction

  assign target    = TOP_NODE_ADDR - 8'(idx);
  assign rd_match  = resp_valid && resp_ok && (resp_data == wr_word);
  assign last_node = (idx == cnt_q - IDX_W'(1));

  assign tbl_clear = (st == ST_IDLE) && start;
  assign tbl_we    = (st == ST_READ) && rd_match;
  assign tbl_waddr = idx;
  assign tbl_wdata = target;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      idx         <= '0;
      cnt_q       <= '0;
      wr_word     <= '0;
      timer_start <= 1'b0;
      req_valid   <= 1'b0;
      req_write   <= 1'b0;
      req_node    <= '0;
      req_reg     <= '0;
      req_data    <= '0;
      done        <= 1'b0;
      error       <= 1'b0;
      fail_idx    <= '0;
    end else begin
      timer_start <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            done     <= 1'b0;
            error    <= 1'b0;
            fail_idx <= '0;
            idx      <= '0;
            cnt_q    <= node_count;
            if (node_count == '0) begin
              done <= 1'b1;
            end else if (node_count > IDX_W'(MAX_NODES)) begin
              error <= 1'b1;
            end else begin
              st        <= ST_WRITE;
              req_valid <= 1'b1;
              req_write <= 1'b1;
              req_node  <= OPEN_NODE_ADDR;
              req_reg   <= CFG_REG;
              req_data  <= cfg_word(TOP_NODE_ADDR);
              wr_word   <= cfg_word(TOP_NODE_ADDR);
            end
          end
        end
        ST_WRITE: begin
          if (resp_valid) begin
            req_valid <= 1'b0;
            if (resp_ok) begin
              st          <= ST_SETTLE;
              timer_start <= 1'b1;
            end else begin
              st       <= ST_IDLE;
              error    <= 1'b1;
              fail_idx <= idx;
            end
          end
        end
        ST_SETTLE: begin
          if (timer_expired) begin
            st        <= ST_READ;
            req_valid <= 1'b1;
            req_write <= 1'b0;
            req_node  <= target;
            req_data  <= '0;
          end
        end
        ST_READ: begin
          if (resp_valid) begin
            req_valid <= 1'b0;
            if (rd_match) begin
              if (last_node) begin
                st   <= ST_IDLE;
                done <= 1'b1;
              end else begin
                idx <= idx + 1'b1;
                st  <= ST_NEXT;
              end
            end else begin
              st       <= ST_IDLE;
              error    <= 1'b1;
              fail_idx <= idx;
            end
          end
        end
        ST_NEXT: begin
          st        <= ST_WRITE;
          req_valid <= 1'b1;
          req_write <= 1'b1;
          req_node  <= OPEN_NODE_ADDR;
          req_data  <= cfg_word(target);
          wr_word   <= cfg_word(target);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/node_addr_programmer.sv
module node_addr_programmer
  import nap_pkg::*;
#(
  parameter int         MAX_NODES    = 16,
  parameter int         DATA_W       = 32,
  parameter logic [7:0] CFG_REG      = 8'h03,
  parameter int         SEND_DELAY   = 2,
  parameter int         PRESCALE     = 1000,
  parameter int         SETTLE_TICKS = 1000,
  localparam int        IDX_W        = $clog2(MAX_NODES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  node_count,
  output logic              req_valid,
  output logic              req_write,
  output logic [7:0]        req_node,
  output logic [7:0]        req_reg,
  output logic [DATA_W-1:0] req_data,
  input  logic              resp_valid,
  input  logic              resp_ok,
  input  logic [DATA_W-1:0] resp_data,
  input  logic [IDX_W-1:0]  tbl_idx,
  output logic [7:0]        tbl_addr,
  output logic              tbl_valid,
  output logic              done,
  output logic              error,
  output logic [IDX_W-1:0]  fail_idx
);
  localparam int AW        = (MAX_NODES > 1) ? $clog2(MAX_NODES) : 1;
  localparam int DELAY_LO  = (SEND_DELAY < MIN_SEND_DELAY) ? MIN_SEND_DELAY : SEND_DELAY;
  localparam int DELAY_EFF = (DELAY_LO > 15) ? 15 : DELAY_LO;

  logic             timer_start;
  logic             timer_expired;
  logic             tbl_clear;
  logic             tbl_we;
  logic [IDX_W-1:0] tbl_waddr;
  logic [7:0]       tbl_wdata;

  nap_sequencer #(
    .MAX_NODES  (MAX_NODES),
    .IDX_W      (IDX_W),
    .DATA_W     (DATA_W),
    .CFG_REG    (CFG_REG),
    .DELAY_FIELD(4'(DELAY_EFF))
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .node_count   (node_count),
    .timer_expired(timer_expired),
    .timer_start  (timer_start),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_node     (req_node),
    .req_reg      (req_reg),
    .req_data     (req_data),
    .resp_valid   (resp_valid),
    .resp_ok      (resp_ok),
    .resp_data    (resp_data),
    .tbl_clear    (tbl_clear),
    .tbl_we       (tbl_we),
    .tbl_waddr    (tbl_waddr),
    .tbl_wdata    (tbl_wdata),
    .done         (done),
    .error        (error),
    .fail_idx     (fail_idx)
  );

  nap_settle_timer #(
    .PRESCALE    (PRESCALE),
    .SETTLE_TICKS(SETTLE_TICKS)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (timer_start),
    .expired(timer_expired)
  );

  nap_addr_table #(
    .DEPTH(MAX_NODES),
    .IDX_W(IDX_W),
    .AW   (AW)
  ) u_table (
    .clk   (clk),
    .rst   (rst),
    .clear (tbl_clear),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (tbl_idx),
    .rdata (tbl_addr),
    .rvalid(tbl_valid)
  );
endmodule

// File: rtl/nap_checker.sv
module nap_checker #(
  parameter int         MAX_NODES    = 16,
  parameter int         PRESCALE     = 1000,
  parameter int         SETTLE_TICKS = 1000,
  parameter logic [7:0] CFG_REG      = 8'h03
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [7:0]  req_node,
  input logic [7:0]  req_reg,
  input logic [11:0] req_cfg,
  input logic        resp_valid,
  input logic        resp_ok,
  input logic        done,
  input logic        error
);
  localparam logic [31:0] SETTLE_CYC = 32'(PRESCALE * SETTLE_TICKS);
  localparam logic [7:0]  ADDR_FLOOR = 8'(255 - MAX_NODES);

  logic [31:0] since_ack;
  logic [7:0]  last_wr_node;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_ack    <= '0;
      last_wr_node <= '0;
    end else begin
      if (req_valid && req_write && resp_valid && resp_ok) since_ack <= '0;
      else if (since_ack != 32'hFFFF_FFFF)                 since_ack <= since_ack + 1'b1;
      if (req_valid && req_write) last_wr_node <= req_cfg[7:0];
    end
  end

  a_r2_open_node: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write |-> (req_node == 8'd0) && (req_reg == CFG_REG));

  a_r3_delay_floor: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write |-> req_cfg[11:8] >= 4'd2);

  a_r1_addr_window: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write |-> (req_cfg[7:0] <= 8'd254) && (req_cfg[7:0] >= ADDR_FLOOR));

  a_r6_verify_target: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write |-> (req_node == last_wr_node) && (req_reg == CFG_REG));

  a_r5_settle_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) && !req_write |-> since_ack >= SETTLE_CYC);

  a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
    req_valid && !resp_valid |=> req_valid && $stable(req_node) && $stable(req_cfg)
                                  && $stable(req_write) && $stable(req_reg));

  a_r8_drop_request: assert property (@(posedge clk) disable iff (rst)
    req_valid && resp_valid |=> !req_valid);

  a_r9_done_error_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
endmodule

bind node_addr_programmer nap_checker #(
  .MAX_NODES   (MAX_NODES),
  .PRESCALE    (PRESCALE),
  .SETTLE_TICKS(SETTLE_TICKS),
  .CFG_REG     (CFG_REG)
) u_nap_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_node  (req_node),
  .req_reg   (req_reg),
  .req_cfg   (req_data[11:0]),
  .resp_valid(resp_valid),
  .resp_ok   (resp_ok),
  .done      (done),
  .error     (error)
);

// File: tb/node_addr_programmer_test.sv
`timescale 1ns/1ps
module node_addr_programmer_test;
  localparam int MAXN  = 6;
  localparam int P     = 3;
  localparam int T     = 4;
  localparam int LAT   = 2;
  localparam int IDX_W = $clog2(MAXN + 1);
  localparam int DW    = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [IDX_W-1:0] node_count = '0;
  logic             req_valid, req_write;
  logic [7:0]       req_node, req_reg;
  logic [DW-1:0]    req_data;
  logic             resp_valid = 1'b0, resp_ok = 1'b0;
  logic [DW-1:0]    resp_data = '0;
  logic [IDX_W-1:0] tbl_idx = '0;
  logic [7:0]       tbl_addr;
  logic             tbl_valid, done, error;
  logic [IDX_W-1:0] fail_idx;

  node_addr_programmer #(
    .MAX_NODES(MAXN), .DATA_W(DW), .CFG_REG(8'h03), .SEND_DELAY(1),
    .PRESCALE(P), .SETTLE_TICKS(T)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .node_count(node_count),
    .req_valid(req_valid), .req_write(req_write), .req_node(req_node),
    .req_reg(req_reg), .req_data(req_data), .resp_valid(resp_valid),
    .resp_ok(resp_ok), .resp_data(resp_data), .tbl_idx(tbl_idx),
    .tbl_addr(tbl_addr), .tbl_valid(tbl_valid), .done(done),
    .error(error), .fail_idx(fail_idx)
  );

  always #2 clk = ~clk;

  int total = 0, fails = 0, cyc = 0, ack_cyc = 0, mism = 0;
  int wr_count = 0, rd_count = 0, ndev = 0, nack_at = -1, bad_at = -1;
  bit run_active = 0;
  bit          dev_prog [MAXN];
  logic [31:0] dev_word [MAXN];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-clock reference: no request outside a run, never done with error
  always @(negedge clk) begin
    if (!rst) begin
      if (!run_active && req_valid) mism++;
      if (done && error) mism++;
    end
  end

  // behavioural device chain and response model
  initial begin : responder
    bit          ok, w;
    logic [31:0] d;
    logic [7:0]  n0;
    logic [31:0] d0;
    int          j;
    forever begin
      @(negedge clk);
      if (req_valid && !rst) begin
        ok = 0; d = '0; w = req_write; n0 = req_node; d0 = req_data;
        if (w) begin
          chk(req_node == 8'd0, "R2", "write node", req_node, 0);
          chk(req_reg == 8'h03, "R2", "write reg", req_reg, 3);
          chk(req_data[7:0] == 8'(254 - wr_count), "R1", "write address", req_data[7:0], 254 - wr_count);
          chk(req_data[31:12] == '0, "R1", "upper data bits", req_data[31:12], 0);
          chk(req_data[11:8] == 4'd2, "R3", "send delay field", req_data[11:8], 2);
          chk(wr_count == rd_count, "R4", "write before prior verify", wr_count, rd_count);
          j = -1;
          for (int k = 0; k < ndev; k++) if (j < 0 && !dev_prog[k]) j = k;
          if (j >= 0 && j != nack_at) begin
            dev_prog[j] = 1; dev_word[j] = req_data; ok = 1;
          end
          wr_count++;
        end else begin
          chk(req_node == 8'(254 - rd_count), "R6", "readback node", req_node, 254 - rd_count);
          chk(req_reg == 8'h03, "R6", "readback reg", req_reg, 3);
          chk((cyc - ack_cyc >= P*T) && (cyc - ack_cyc <= P*T + 5), "R5", "settle gap",
              cyc - ack_cyc, P*T + 2);
          for (int k = 0; k < ndev; k++)
            if (!ok && dev_prog[k] && dev_word[k][7:0] == req_node) begin
              ok = 1; d = dev_word[k];
              if (k == bad_at) d = d ^ 32'h1;
            end
          rd_count++;
        end
        for (int q = 0; q < LAT; q++) begin
          @(negedge clk);
          chk(req_valid && req_node == n0 && req_data == d0 && req_write == w,
              "R8", "request held", req_valid, 1);
        end
        resp_valid = 1; resp_ok = ok; resp_data = d;
        if (w && ok) ack_cyc = cyc;
        @(negedge clk);
        resp_valid = 0; resp_ok = 0; resp_data = '0;
        chk(!req_valid, "R8", "request dropped", req_valid, 0);
      end
    end
  end

  task automatic read_tbl(input int i, output logic [7:0] a, output logic v);
    tbl_idx = IDX_W'(i);
    @(negedge clk);
    @(negedge clk);
    a = tbl_addr; v = tbl_valid;
  endtask

  task automatic run(input int n, input int nd, input int nk, input int bd, input bit mid,
                     input int ewr, input int erd, input bit edone, input bit eerr,
                     input int efi, input string tag);
    int w;
    for (int k = 0; k < MAXN; k++) begin dev_prog[k] = 0; dev_word[k] = '0; end
    wr_count = 0; rd_count = 0; ndev = nd; nack_at = nk; bad_at = bd; mism = 0;
    @(negedge clk);
    node_count = IDX_W'(n); start = 1; run_active = 1;
    @(negedge clk);
    start = 0;
    w = 0;
    while (!(done || error) && w < 5000) begin
      if (mid && w == 20) begin start = 1; node_count = IDX_W'(2); end
      if (mid && w == 21) start = 0;
      @(negedge clk);
      w++;
    end
    start = 0;
    repeat (4) @(negedge clk);
    run_active = 0;
    repeat (2) @(negedge clk);
    chk(done == edone, tag, "done", done, edone);
    chk(error == eerr, tag, "error", error, eerr);
    if (eerr) chk(fail_idx == IDX_W'(efi), tag, "fail_idx", fail_idx, efi);
    chk(wr_count == ewr, tag, "write count", wr_count, ewr);
    chk(rd_count == erd, tag, "read count", rd_count, erd);
    chk(mism == 0, tag, "per-clock reference mismatches", mism, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    logic [7:0] a;
    logic       v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12: reset state
    chk(!done && !error && !req_valid, "R12", "flags after reset", {done, error, req_valid}, 0);
    read_tbl(0, a, v);
    chk(!v, "R12", "entry 0 valid after reset", v, 0);

    // R9: normal walk of four devices
    run(4, 6, -1, -1, 0, 4, 4, 1, 0, 0, "R9");
    for (int i = 0; i < 4; i++) begin
      read_tbl(i, a, v);
      chk(v && a == 8'(254 - i), "R9", "table entry", {v, a}, {1'b1, 8'(254 - i)});
    end
    read_tbl(4, a, v);
    chk(!v, "R9", "entry 4 unverified", v, 0);

    // R11: start in mid-walk ignored, full MAXN walk (boundary)
    run(MAXN, MAXN, -1, -1, 1, MAXN, MAXN, 1, 0, 0, "R11");
    read_tbl(MAXN - 1, a, v);
    chk(v && a == 8'(255 - MAXN), "R1", "last entry address", a, 255 - MAXN);

    // R7: refused write at index 2 stops the walk
    run(5, 6, 2, -1, 0, 3, 2, 0, 1, 2, "R7");
    read_tbl(1, a, v);
    chk(v && a == 8'd253, "R7", "entry 1 kept", a, 253);
    read_tbl(2, a, v);
    chk(!v, "R7", "entry 2 not verified", v, 0);
    read_tbl(5, a, v);
    chk(!v, "R11", "entry 5 cleared by new start", v, 0);

    // R6: corrupted readback at index 1
    run(3, 6, -1, 1, 0, 2, 2, 0, 1, 1, "R6");
    read_tbl(1, a, v);
    chk(!v, "R6", "entry 1 not verified", v, 0);

    // R4: missing third device refuses, walk stops in order
    run(3, 2, -1, -1, 0, 3, 2, 0, 1, 2, "R4");

    // R10: empty count and oversized count
    run(0, 6, -1, -1, 0, 0, 0, 1, 0, 0, "R10");
    run(MAXN + 1, 6, -1, -1, 0, 0, 0, 0, 1, 0, "R10");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule